// File: doc/BRIEF.md
# Event-Triggered Register Replay DMA

This block replays a list of register writes that software has placed in memory. Each list entry is 8 bytes: a 32-bit target register address, followed by the 32-bit value to store there. Each channel holds a start byte address and an inclusive end byte address. Each channel also selects the event that launches it: a software kick, the rising edge of a frame-sync input, or the rising edge of a line-count input. On every launching event the channel walks its list once, from the lowest address upward. It fetches each entry over a 32-bit memory read port and issues one write on the register-bus master port. When the list is finished it raises that channel's done interrupt. The channel then stays armed for the next event.

A single sequencer is shared by all channels. When several channels are waiting, the lowest-numbered one goes first. The sequencer handles one entry at a time. It does not fetch an entry until the register bus has accepted the previous write.

Configuration uses a plain write strobe with a combinational read-back. The offsets are: `0x00` control, `0x04` status, `0x08` trigger select, `0x0C` kick. Channel c has its start address at `0x40+8c` and its end address at `0x44+8c`.

Both streaming ports use valid/ready:
- The memory request (`mem_req_*`) holds its valid, and its address stays stable, until ready is seen.
- The response (`mem_rsp_*`) is consumed only while `mem_rsp_ready` is high.
- A register-bus write (`rb_*`) holds valid, address and data stable until `rb_ready`.

Any stage may stall for any number of cycles. A soft reset is the only event that may withdraw a pending request.

Top module: `rdma_replay`

## Requirements
- R1: Entry k of a list sits at start+8k: the target address word comes first, then the value word. The channel issues exactly floor((end+1−start)/8) register writes, in memory order. A list whose first entry does not fit before end issues no write, yet still raises its done interrupt.
- R2: Trigger-select bits [4c+1:4c] choose channel c's source: 0 stop, 1 kick (write 1 to bit c at `0x0C`), 2 frame-sync rising edge, 3 line-count rising edge. Events from any other source, and every event in code 0, leave the channel idle.
- R3: Each launching event runs the list exactly once. A level held high counts as one event. The channel stays armed and runs again on the next event.
- R4: When a list finishes, irq[c] and status bit c are set. They stay set until software writes 1 to control bit 8+c.
- R5: A launching event that arrives while channel c is busy is dropped and sets status bit 8+c (overrun). This bit is sticky until software writes 1 to status bit 8+c.
- R6: Writes to channel c's start or end address are ignored while status bit 16+c (busy: waiting or running) is set.
- R7: The direction flag at trigger-select bit 4c+2 must be 1 (write) for the channel to run. A channel with this flag at 0 ignores its events and raises no interrupt. When the increment flag at bit 4c+3 is 1, write k goes to (address word of entry 0)+4k instead of entry k's own address word.
- R8: Writing 1 to control bit 0 returns every channel and the sequencer to idle. It clears waiting, running, interrupt and overrun state and drops any write in flight. The bit reads back as 0.
- R9: Control bits [19:16] (write burst) and [23:20] (read burst) are stored and read back. They reset to 3 and 0.
- R10: Only one channel runs at a time. Among waiting channels, the lowest index starts first, and its whole list completes before another channel begins.
- R11: A memory request or register-bus write holds valid and its address and data stable until accepted. The next entry is fetched only after the register bus accepts the current write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (combinational) |
| frame_evt | input | 1 | Frame-sync event level |
| line_evt | input | 1 | Line-count event level |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory read request accepted |
| mem_req_addr | output | 32 | Memory read byte address |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_ready | output | 1 | Engine accepts read data |
| mem_rsp_data | input | 32 | Memory read data |
| rb_valid | output | 1 | Register-bus write valid |
| rb_ready | input | 1 | Register-bus write accepted |
| rb_addr | output | 32 | Register-bus target address |
| rb_data | output | 32 | Register-bus write value |
| irq | output | 8 | Per-channel done interrupt |

## Verification
A corrupted list pointer or increment offset shows up at `rb_addr` on the very next accepted write. That is at most five unstalled cycles after the previous one. A wrong waiting or running bit shows as a missing, extra or out-of-order run. This becomes visible in the write sequence, `irq` or status busy bits within one list's duration. A stuck overrun or interrupt bit is visible at the status read right after the clearing write. An abort that fails to clear state shows on the status read in the cycle after the soft-reset pulse.

// File: rtl/rdma_replay_pkg.sv
package rdma_replay_pkg;
  typedef enum logic [1:0] {
    TRG_STOP   = 2'd0,
    TRG_KICK   = 2'd1,
    TRG_FRAME  = 2'd2,
    TRG_LINE   = 2'd3
  } trg_sel_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_REQ_A, SQ_RSP_A, SQ_REQ_D, SQ_RSP_D, SQ_WRITE, SQ_DONE
  } sq_state_e;

  localparam int ENTRY_BYTES = 8;
  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h04;
  localparam logic [7:0] OFS_TSEL = 8'h08;
  localparam logic [7:0] OFS_KICK = 8'h0C;
  localparam logic [7:0] OFS_LIST = 8'h40;
  localparam logic [3:0] WR_BURST_RST = 4'd3;
  localparam logic [3:0] RD_BURST_RST = 4'd0;
endpackage

// File: rtl/rdma_cfg_regs.sv
module rdma_cfg_regs
  import rdma_replay_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int AW     = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [7:0]                  cfg_addr,
  input  logic [31:0]                 cfg_wdata,
  output logic [31:0]                 cfg_rdata,
  input  logic [NUM_CH-1:0]           busy_i,
  input  logic [NUM_CH-1:0]           irq_i,
  input  logic [NUM_CH-1:0]           ovr_i,
  output logic [NUM_CH-1:0][1:0]      trg_sel_o,
  output logic [NUM_CH-1:0]           wr_flag_o,
  output logic [NUM_CH-1:0]           inc_flag_o,
  output logic [NUM_CH-1:0][AW-1:0]   start_o,
  output logic [NUM_CH-1:0][AW-1:0]   end_o,
  output logic [NUM_CH-1:0]           kick_o,
  output logic [NUM_CH-1:0]           irq_clr_o,
  output logic [NUM_CH-1:0]           ovr_clr_o,
  output logic                        soft_rst_o
);
  localparam int TW = 4 * NUM_CH;

  logic [TW-1:0]           tsel_q;
  logic [3:0]              wr_burst_q, rd_burst_q;
  logic                    soft_rst_q;
  logic [NUM_CH-1:0][AW-1:0] start_q, end_q;

  wire wr_ctrl = cfg_we && (cfg_addr == OFS_CTRL);
  wire wr_stat = cfg_we && (cfg_addr == OFS_STAT);
  wire wr_tsel = cfg_we && (cfg_addr == OFS_TSEL);
  wire wr_kick = cfg_we && (cfg_addr == OFS_KICK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tsel_q     <= '0;
      wr_burst_q <= WR_BURST_RST;
      rd_burst_q <= RD_BURST_RST;
      soft_rst_q <= 1'b0;
    end else begin
      soft_rst_q <= wr_ctrl && cfg_wdata[0];
      if (wr_ctrl) begin
        wr_burst_q <= cfg_wdata[19:16];
        rd_burst_q <= cfg_wdata[23:20];
      end
      if (wr_tsel) tsel_q <= cfg_wdata[TW-1:0];
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [7:0] A_START = OFS_LIST + 8'(8 * c);
    localparam logic [7:0] A_END   = OFS_LIST + 8'(8 * c + 4);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        start_q[c] <= '0;
        end_q[c]   <= '0;
      end else if (cfg_we && !busy_i[c]) begin
        if (cfg_addr == A_START) start_q[c] <= cfg_wdata[AW-1:0];
        if (cfg_addr == A_END)   end_q[c]   <= cfg_wdata[AW-1:0];
      end
    end

    assign trg_sel_o[c]  = tsel_q[4*c +: 2];
    assign wr_flag_o[c]  = tsel_q[4*c + 2];
    assign inc_flag_o[c] = tsel_q[4*c + 3];
    assign kick_o[c]     = wr_kick && cfg_wdata[c];
    assign irq_clr_o[c]  = wr_ctrl && cfg_wdata[8 + c];
    assign ovr_clr_o[c]  = wr_stat && cfg_wdata[8 + c];

    // R6
    start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == A_START && busy_i[c]) |=> $stable(start_q[c]));
    // R6
    end_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == A_END && busy_i[c]) |=> $stable(end_q[c]));
  end

  assign start_o    = start_q;
  assign end_o      = end_q;
  assign soft_rst_o = soft_rst_q;

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      OFS_CTRL: cfg_rdata = {8'h0, rd_burst_q, wr_burst_q, 16'h0};
      OFS_STAT: begin
        cfg_rdata[NUM_CH-1:0]       = irq_i;
        cfg_rdata[8 +: NUM_CH]      = ovr_i;
        cfg_rdata[16 +: NUM_CH]     = busy_i;
      end
      OFS_TSEL: cfg_rdata[TW-1:0] = tsel_q;
      default: begin
        for (int c = 0; c < NUM_CH; c++) begin
          if (cfg_addr == OFS_LIST + 8'(8 * c))     cfg_rdata = 32'(start_q[c]);
          if (cfg_addr == OFS_LIST + 8'(8 * c + 4)) cfg_rdata = 32'(end_q[c]);
        end
      end
    endcase
  end

  // R8
  soft_rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_q |=> !soft_rst_q);
endmodule

// File: rtl/rdma_chan_ctl.sv
module rdma_chan_ctl
  import rdma_replay_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CHW = $clog2(NUM_CH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   soft_rst,
  input  logic [NUM_CH-1:0][1:0] trg_sel,
  input  logic [NUM_CH-1:0]      wr_flag,
  input  logic [NUM_CH-1:0]      kick,
  input  logic                   frame_evt,
  input  logic                   line_evt,
  input  logic                   take,
  input  logic                   done,
  input  logic [CHW-1:0]         done_ch,
  input  logic [NUM_CH-1:0]      irq_clr,
  input  logic [NUM_CH-1:0]      ovr_clr,
  output logic [NUM_CH-1:0]      busy,
  output logic [NUM_CH-1:0]      irq_pend,
  output logic [NUM_CH-1:0]      overrun,
  output logic                   grant_valid,
  output logic [CHW-1:0]         grant_ch
);
  logic frame_q, line_q;
  logic [NUM_CH-1:0] pending, running, trig;

  wire frame_edge = frame_evt && !frame_q;
  wire line_edge  = line_evt && !line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= 1'b0;
      line_q  <= 1'b0;
    end else begin
      frame_q <= frame_evt;
      line_q  <= line_evt;
    end
  end

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      unique case (trg_sel_e'(trg_sel[c]))
        TRG_KICK:  trig[c] = wr_flag[c] && kick[c];
        TRG_FRAME: trig[c] = wr_flag[c] && frame_edge;
        TRG_LINE:  trig[c] = wr_flag[c] && line_edge;
        default:   trig[c] = 1'b0;
      endcase
    end
  end

  assign busy = pending | running;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending  <= '0;
      running  <= '0;
      irq_pend <= '0;
      overrun  <= '0;
    end else if (soft_rst) begin
      pending  <= '0;
      running  <= '0;
      irq_pend <= '0;
      overrun  <= '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (take && grant_ch == CHW'(c)) begin
          pending[c] <= 1'b0;
          running[c] <= 1'b1;
        end else if (trig[c] && !busy[c]) begin
          pending[c] <= 1'b1;
        end
        if (done && done_ch == CHW'(c)) running[c] <= 1'b0;

        if (trig[c] && busy[c])  overrun[c] <= 1'b1;
        else if (ovr_clr[c])     overrun[c] <= 1'b0;

        if (done && done_ch == CHW'(c)) irq_pend[c] <= 1'b1;
        else if (irq_clr[c])            irq_pend[c] <= 1'b0;
      end
    end
  end

  always_comb begin
    grant_valid = 1'b0;
    grant_ch    = '0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (pending[c]) begin
        grant_valid = 1'b1;
        grant_ch    = CHW'(c);
      end
    end
  end

  // R10
  one_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(running));
  // R4
  done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    done |=> irq_pend[$past(done_ch)]);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R5
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
      (trig[c] && busy[c]) |=> overrun[c]);
  end
endmodule

// File: rtl/rdma_seq.sv
module rdma_seq
  import rdma_replay_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int AW     = 32,
  parameter int DW     = 32,
  localparam int CHW = $clog2(NUM_CH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      soft_rst,
  input  logic                      grant_valid,
  input  logic [CHW-1:0]            grant_ch,
  input  logic [NUM_CH-1:0][AW-1:0] start_i,
  input  logic [NUM_CH-1:0][AW-1:0] end_i,
  input  logic [NUM_CH-1:0]         inc_i,
  output logic                      take_o,
  output logic                      done_o,
  output logic [CHW-1:0]            done_ch_o,
  output logic                      mem_req_valid,
  input  logic                      mem_req_ready,
  output logic [AW-1:0]             mem_req_addr,
  input  logic                      mem_rsp_valid,
  output logic                      mem_rsp_ready,
  input  logic [DW-1:0]             mem_rsp_data,
  output logic                      rb_valid,
  input  logic                      rb_ready,
  output logic [DW-1:0]             rb_addr,
  output logic [DW-1:0]             rb_data
);
  sq_state_e state_q;
  logic [CHW-1:0] ch_q;
  logic [AW-1:0]  cur_q, end_q;
  logic           inc_q, first_q;
  logic [DW-1:0]  base_q, off_q, tgt_q, val_q;

  function automatic logic fits(input logic [AW:0] a, input logic [AW-1:0] e);
    return ({1'b0, a} + (AW+2)'(ENTRY_BYTES - 1)) <= {2'b0, e};
  endfunction

  wire [AW:0] next_cur = {1'b0, cur_q} + (AW+1)'(ENTRY_BYTES);

  assign take_o        = (state_q == SQ_IDLE) && grant_valid;
  assign done_o        = (state_q == SQ_DONE);
  assign done_ch_o     = ch_q;
  assign mem_req_valid = (state_q == SQ_REQ_A) || (state_q == SQ_REQ_D);
  assign mem_req_addr  = (state_q == SQ_REQ_D) ? cur_q + AW'(4) : cur_q;
  assign mem_rsp_ready = (state_q == SQ_RSP_A) || (state_q == SQ_RSP_D);
  assign rb_valid      = (state_q == SQ_WRITE);
  assign rb_addr       = tgt_q;
  assign rb_data       = val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      ch_q    <= '0;
      cur_q   <= '0;
      end_q   <= '0;
      inc_q   <= 1'b0;
      first_q <= 1'b0;
      base_q  <= '0;
      off_q   <= '0;
      tgt_q   <= '0;
      val_q   <= '0;
    end else if (soft_rst) begin
      state_q <= SQ_IDLE;
    end else begin
      unique case (state_q)
        SQ_IDLE: if (grant_valid) begin
          ch_q    <= grant_ch;
          cur_q   <= start_i[grant_ch];
          end_q   <= end_i[grant_ch];
          inc_q   <= inc_i[grant_ch];
          first_q <= 1'b1;
          off_q   <= '0;
          state_q <= fits({1'b0, start_i[grant_ch]}, end_i[grant_ch]) ? SQ_REQ_A : SQ_DONE;
        end
        SQ_REQ_A: if (mem_req_ready) state_q <= SQ_RSP_A;
        SQ_RSP_A: if (mem_rsp_valid) begin
          if (first_q) base_q <= mem_rsp_data;
          tgt_q   <= (inc_q && !first_q) ? base_q + off_q : mem_rsp_data;
          state_q <= SQ_REQ_D;
        end
        SQ_REQ_D: if (mem_req_ready) state_q <= SQ_RSP_D;
        SQ_RSP_D: if (mem_rsp_valid) begin
          val_q   <= mem_rsp_data;
          state_q <= SQ_WRITE;
        end
        SQ_WRITE: if (rb_ready) begin
          cur_q   <= next_cur[AW-1:0];
          off_q   <= off_q + DW'(4);
          first_q <= 1'b0;
          state_q <= fits(next_cur, end_q) ? SQ_REQ_A : SQ_DONE;
        end
        SQ_DONE: state_q <= SQ_IDLE;
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  // R11
  rb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (rb_valid && !rb_ready) |=> (rb_valid && $stable(rb_addr) && $stable(rb_data)));
  // R11
  mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  // R11
  fetch_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (rb_valid && !rb_ready) |=> !mem_req_valid);
endmodule

// File: rtl/rdma_replay.sv
module rdma_replay
  import rdma_replay_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int AW     = 32,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              frame_evt,
  input  logic              line_evt,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [AW-1:0]     mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [DW-1:0]     mem_rsp_data,
  output logic              rb_valid,
  input  logic              rb_ready,
  output logic [DW-1:0]     rb_addr,
  output logic [DW-1:0]     rb_data,
  output logic [NUM_CH-1:0] irq
);
  localparam int CHW = $clog2(NUM_CH);

  logic [NUM_CH-1:0][1:0]    trg_sel;
  logic [NUM_CH-1:0]         wr_flag, inc_flag, kick, irq_clr, ovr_clr;
  logic [NUM_CH-1:0]         busy, irq_pend, overrun;
  logic [NUM_CH-1:0][AW-1:0] start_a, end_a;
  logic                      soft_rst, take, done, grant_valid;
  logic [CHW-1:0]            done_ch, grant_ch;

  rdma_cfg_regs #(.NUM_CH(NUM_CH), .AW(AW)) u_regs (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
    .busy_i(busy), .irq_i(irq_pend), .ovr_i(overrun),
    .trg_sel_o(trg_sel), .wr_flag_o(wr_flag), .inc_flag_o(inc_flag),
    .start_o(start_a), .end_o(end_a), .kick_o(kick),
    .irq_clr_o(irq_clr), .ovr_clr_o(ovr_clr), .soft_rst_o(soft_rst)
  );

  rdma_chan_ctl #(.NUM_CH(NUM_CH)) u_ctl (
    .clk, .rst_n, .soft_rst, .trg_sel, .wr_flag, .kick,
    .frame_evt, .line_evt, .take, .done, .done_ch, .irq_clr, .ovr_clr,
    .busy, .irq_pend, .overrun, .grant_valid, .grant_ch
  );

  rdma_seq #(.NUM_CH(NUM_CH), .AW(AW), .DW(DW)) u_seq (
    .clk, .rst_n, .soft_rst, .grant_valid, .grant_ch,
    .start_i(start_a), .end_i(end_a), .inc_i(inc_flag),
    .take_o(take), .done_o(done), .done_ch_o(done_ch),
    .mem_req_valid, .mem_req_ready, .mem_req_addr,
    .mem_rsp_valid, .mem_rsp_ready, .mem_rsp_data,
    .rb_valid, .rb_ready, .rb_addr, .rb_data
  );

  assign irq = irq_pend;

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|busy)) |-> !rb_valid);
endmodule

// File: tb/rdma_replay_tb.sv
`timescale 1ns/1ps
module rdma_replay_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic        frame_evt = 1'b0, line_evt = 1'b0;
  logic        mem_req_valid, mem_req_ready, mem_rsp_valid, mem_rsp_ready;
  logic [31:0] mem_req_addr, mem_rsp_data;
  logic        rb_valid, rb_ready;
  logic [31:0] rb_addr, rb_data;
  logic [7:0]  irq;

  rdma_replay u_dut (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
    .frame_evt, .line_evt,
    .mem_req_valid, .mem_req_ready, .mem_req_addr,
    .mem_rsp_valid, .mem_rsp_ready, .mem_rsp_data,
    .rb_valid, .rb_ready, .rb_addr, .rb_data, .irq
  );

  int ntest = 0, nfail = 0;
  logic [31:0] mem [0:1023];
  logic [31:0] log_a [0:63];
  logic [31:0] log_d [0:63];
  int  nlog = 0;
  int  proto_err = 0;
  int  cyc = 0;
  bit  stall = 1'b0;
  logic [31:0] tsel = '0;

  assign mem_req_ready = stall ? cyc[0] : 1'b1;
  assign rb_ready      = stall ? (cyc[1:0] == 2'd3) : 1'b1;

  logic        p_rbv, p_rbr;
  logic [31:0] p_rba, p_rbd;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= mem[mem_req_addr[11:2]];
    end else if (mem_rsp_valid && mem_rsp_ready) begin
      mem_rsp_valid <= 1'b0;
    end
    if (rb_valid && rb_ready && nlog < 64) begin
      log_a[nlog] <= rb_addr;
      log_d[nlog] <= rb_data;
      nlog <= nlog + 1;
    end
    if (rst_n && p_rbv && !p_rbr && (!rb_valid || rb_addr != p_rba || rb_data != p_rbd))
      proto_err <= proto_err + 1;
    p_rbv <= rb_valid; p_rbr <= rb_ready; p_rba <= rb_addr; p_rbd <= rb_data;
  end
  initial begin
    mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    p_rbv = 1'b0; p_rbr = 1'b0; p_rba = '0; p_rbd = '0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    ntest++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); cfg_addr = a; #1 d = cfg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] tgt_of(input int start, input int k);
    return 32'h4000_0000 + 32'(start << 4) + 32'(k * 16);
  endfunction
  function automatic logic [31:0] val_of(input int start, input int k);
    return 32'hD000_0000 ^ 32'(start << 8) ^ 32'(k);
  endfunction

  task automatic fill(input int start, input int n);
    for (int k = 0; k < n; k++) begin
      mem[(start >> 2) + 2*k]     = tgt_of(start, k);
      mem[(start >> 2) + 2*k + 1] = val_of(start, k);
    end
  endtask

  task automatic setup_ch(input int ch, input int mode, input bit wflag, input bit inc,
                          input int start, input int endb);
    tsel[4*ch +: 4] = {inc, wflag, 2'(mode)};
    cfg_wr(8'h08, tsel);
    cfg_wr(8'(8'h40 + 8*ch), 32'(start));
    cfg_wr(8'(8'h44 + 8*ch), 32'(endb));
  endtask

  task automatic pulse(input int mode, input int ch);
    if (mode == 1) cfg_wr(8'h0C, 32'(1 << ch));
    else begin
      @(negedge clk);
      if (mode == 2) frame_evt = 1'b1; else line_evt = 1'b1;
      idle(3);
      frame_evt = 1'b0; line_evt = 1'b0;
    end
  endtask

  task automatic wait_irq(input int ch, input string req);
    int t = 0;
    while (!irq[ch] && t < 3000) begin @(negedge clk); t++; end
    if (!irq[ch]) begin
      ntest++; nfail++;
      $display("FAIL %s actual=irq_low expected=irq_high", req);
    end
  endtask

  task automatic chk_list(input string req, input int base, input int start, input int n, input bit inc);
    for (int k = 0; k < n; k++) begin
      chk(req, log_a[base + k], inc ? tgt_of(start, 0) + 32'(4*k) : tgt_of(start, k));
      chk(req, log_d[base + k], val_of(start, k));
    end
  endtask

  typedef struct packed {
    logic [2:0]  ch;
    logic [1:0]  mode;
    logic        inc;
    logic        stl;
    logic [3:0]  n;
    logic [11:0] start;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{ch: 3'd1, mode: 2'd1, inc: 1'b0, stl: 1'b0, n: 4'd3, start: 12'h100},
    '{ch: 3'd0, mode: 2'd2, inc: 1'b0, stl: 1'b0, n: 4'd1, start: 12'h000},
    '{ch: 3'd5, mode: 2'd3, inc: 1'b1, stl: 1'b0, n: 4'd4, start: 12'h200},
    '{ch: 3'd7, mode: 2'd2, inc: 1'b1, stl: 1'b1, n: 4'd2, start: 12'h300},
    '{ch: 3'd2, mode: 2'd1, inc: 1'b0, stl: 1'b1, n: 4'd6, start: 12'h400}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    idle(4);
    rst_n = 1'b1;
    idle(2);

    // reset state: R9, R4
    cfg_rd(8'h04, rd); chk("R4 reset status", rd, 32'h0);
    cfg_rd(8'h00, rd); chk("R9 reset burst", rd, 32'h0003_0000);
    chk("R4 reset irq", 32'(irq), 32'h0);
    chk("R11 reset rb_valid", 32'(rb_valid), 32'h0);

    // table walk: R1 R2 R4 R7 R11
    foreach (VECS[v]) begin
      int ch, st, n;
      ch = int'(VECS[v].ch); st = int'(VECS[v].start); n = int'(VECS[v].n);
      nlog = 0;
      fill(st, n);
      stall = VECS[v].stl;
      setup_ch(ch, int'(VECS[v].mode), 1'b1, VECS[v].inc, st, st + 8*n - 1);
      pulse(int'(VECS[v].mode), ch);
      wait_irq(ch, "R4 vector done");
      idle(2);
      chk("R1 write count", 32'(nlog), 32'(n));
      chk_list("R1 R7 entry order", 0, st, n, VECS[v].inc);
      cfg_rd(8'h04, rd); chk("R4 status irq bit", rd, 32'(1 << ch));
      cfg_wr(8'h00, 32'h0003_0000 | 32'(1 << (8 + ch)));
      chk("R4 irq cleared", 32'(irq), 32'h0);
      tsel = '0; cfg_wr(8'h08, tsel);
      stall = 1'b0;
    end

    // R2: wrong source and stop code
    nlog = 0;
    fill(32'h500, 2);
    setup_ch(3, 2, 1'b1, 1'b0, 32'h500, 32'h50F);
    pulse(3, 3); idle(40);
    chk("R2 line ignored in frame mode", 32'(nlog), 32'h0);
    cfg_rd(8'h04, rd); chk("R2 no busy", rd, 32'h0);
    setup_ch(3, 0, 1'b1, 1'b0, 32'h500, 32'h50F);
    pulse(2, 3); idle(40);
    chk("R2 stop code ignores frame", 32'(nlog), 32'h0);

    // R3: one run per event, re-armed
    setup_ch(3, 2, 1'b1, 1'b0, 32'h500, 32'h50F);
    pulse(2, 3);
    wait_irq(3, "R3 first run"); idle(20);
    chk("R3 single run per event", 32'(nlog), 32'h2);
    cfg_wr(8'h00, 32'h0003_0000 | 32'(1 << 11));
    pulse(2, 3);
    wait_irq(3, "R3 second run"); idle(5);
    chk("R3 rearmed count", 32'(nlog), 32'h4);
    chk_list("R3 rerun content", 2, 32'h500, 2, 1'b0);
    cfg_wr(8'h00, 32'h0003_0000 | 32'(1 << 11));
    tsel = '0; cfg_wr(8'h08, tsel);

    // R5, R6: overrun and address lock while busy
    nlog = 0; stall = 1'b1;
    fill(32'h600, 8);
    setup_ch(4, 1, 1'b1, 1'b0, 32'h600, 32'h63F);
    pulse(1, 4); idle(4);
    pulse(1, 4);
    cfg_rd(8'h04, rd); chk("R5 overrun set", rd & 32'h0000_1000, 32'h0000_1000);
    chk("R6 busy seen", rd & 32'h0010_0000, 32'h0010_0000);
    cfg_wr(8'h60, 32'h0000_0700);
    cfg_wr(8'h64, 32'h0000_0707);
    cfg_rd(8'h60, rd); chk("R6 start locked", rd, 32'h600);
    cfg_rd(8'h64, rd); chk("R6 end locked", rd, 32'h63F);
    wait_irq(4, "R5 run done"); idle(200);
    chk("R5 dropped trigger no rerun", 32'(nlog), 32'h8);
    chk_list("R11 stalled content", 0, 32'h600, 8, 1'b0);
    cfg_wr(8'h04, 32'h0000_1000);
    cfg_rd(8'h04, rd); chk("R5 overrun cleared", rd & 32'h0000_FF00, 32'h0);
    cfg_wr(8'h00, 32'h0003_0000 | 32'(1 << 12));
    cfg_wr(8'h60, 32'h0000_0700);
    cfg_rd(8'h60, rd); chk("R6 start writable when idle", rd, 32'h700);
    stall = 1'b0;
    tsel = '0; cfg_wr(8'h08, tsel);

    // R7: direction flag cleared
    nlog = 0;
    setup_ch(6, 1, 1'b0, 1'b0, 32'h500, 32'h50F);
    pulse(1, 6); idle(40);
    chk("R7 read direction no writes", 32'(nlog), 32'h0);
    chk("R7 read direction no irq", 32'(irq), 32'h0);
    tsel = '0; cfg_wr(8'h08, tsel);

    // R1: empty list and partial tail
    nlog = 0;
    setup_ch(1, 1, 1'b1, 1'b0, 32'h100, 32'h106);
    pulse(1, 1);
    wait_irq(1, "R1 empty list irq"); idle(2);
    chk("R1 empty list no writes", 32'(nlog), 32'h0);
    cfg_wr(8'h00, 32'h0003_0200);
    setup_ch(1, 1, 1'b1, 1'b0, 32'h100, 32'h113);
    pulse(1, 1);
    wait_irq(1, "R1 partial tail irq"); idle(2);
    chk("R1 partial tail count", 32'(nlog), 32'h2);
    cfg_wr(8'h00, 32'h0003_0200);
    tsel = '0; cfg_wr(8'h08, tsel);

    // R10: simultaneous launch, lower index first
    nlog = 0;
    fill(32'h200, 3);
    fill(32'h400, 2);
    setup_ch(5, 2, 1'b1, 1'b0, 32'h200, 32'h217);
    setup_ch(2, 2, 1'b1, 1'b0, 32'h400, 32'h40F);
    pulse(2, 0);
    wait_irq(5, "R10 second channel done"); idle(2);
    chk("R10 total writes", 32'(nlog), 32'h5);
    chk_list("R10 low index first", 0, 32'h400, 2, 1'b0);
    chk_list("R10 high index after", 2, 32'h200, 3, 1'b0);
    cfg_wr(8'h00, 32'h0003_2400);
    tsel = '0; cfg_wr(8'h08, tsel);

    chk("R11 rb held until accepted", 32'(proto_err), 32'h0);

    // R9: burst fields
    cfg_wr(8'h00, 32'h0052_0000);
    cfg_rd(8'h00, rd); chk("R9 burst readback", rd, 32'h0052_0000);

    // R8: soft reset mid-run
    nlog = 0; stall = 1'b1;
    setup_ch(4, 1, 1'b1, 1'b0, 32'h600, 32'h63F);
    pulse(1, 4); idle(10);
    cfg_wr(8'h00, 32'h0052_0001);
    cfg_rd(8'h00, rd); chk("R8 bit self-clears", rd, 32'h0052_0000);
    cfg_rd(8'h04, rd); chk("R8 all idle", rd, 32'h0);
    idle(300);
    chk("R8 run aborted no irq", 32'(irq), 32'h0);
    chk("R8 no write after abort", 32'(rb_valid), 32'h0);
    ntest++;
    if (nlog >= 8) begin
      nfail++;
      $display("FAIL R8 abort actual=%0d expected=<8", nlog);
    end

    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end
endmodule